// File: doc/BRIEF.md
# Frame Timestamp Capture Unit

This block runs a free-running timestamp counter and copies its value into a frame timestamp register on every start-of-vblank pulse. From the time elapsed since that capture, it works out where the display scan most likely is. The elapsed time is scaled by a pixels-per-tick ratio and divided by the line length in pixels. The line count is clamped to the frame height and then offset by the first blanking line, so the result is expressed in the normal line numbering. It is used where the pipe's own line counter cannot be trusted and the position has to be reconstructed from time.

An iterative divider recomputes the scanline without pause. Each result is announced with a one-cycle valid pulse. For readers that fetch the current and captured timestamps one after the other, a read window input is provided. While the window is open, a tear flag records any capture that happens inside it. Software then knows the pair may span two frames and must be fetched again.

Top module: `frame_ts_unit`

## Requirements
- R1: While reset is held and after its release, until the first capture or tick: `cur_ts_o` and `frame_ts_o` read 0, `tear_o` and `valid_o` are 0, and `scanline_o` equals `vblank_start_i`.
- R2: `cur_ts_o` advances by exactly one every TICK_DIV clock cycles and wraps modulo 2^TS_W.
- R3: A `vblank_i` high at a clock edge loads `frame_ts_o` with the value `cur_ts_o` had in that cycle. Without the pulse, `frame_ts_o` keeps its value.
- R4: The elapsed line count is ((cur − frame) mod 2^TS_W) × `ratio_i` / `htotal_i`, using integer division. It is correct across counter wraparound.
- R5: The elapsed line count saturates at `vtotal_i` − 1.
- R6: `scanline_o` = (elapsed lines + `vblank_start_i`) mod `vtotal_i`, and it is always below `vtotal_i`.
- R7: `valid_o` is a one-cycle pulse that comes every N_W+1 cycles, where N_W = TS_W+RATIO_W. `scanline_o` holds between pulses. Each result uses the timestamps as they stood N_W+2 cycles before the pulse is seen.
- R8: `tear_o` goes to 1 after a `vblank_i` pulse seen while `rd_open_i` is 1. This includes the cycle in which `rd_open_i` rises. It stays 1 while the window is open and is 0 whenever `rd_open_i` was 0 at the previous edge.
- R9: Until the first result after reset, `scanline_o` follows `vblank_start_i` directly.
- R10: An `htotal_i` of zero yields the saturated count, so `scanline_o` = (`vtotal_i` − 1 + `vblank_start_i`) mod `vtotal_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vblank_i | input | 1 | Start-of-vblank pulse, one cycle |
| rd_open_i | input | 1 | Timestamp pair read window |
| htotal_i | input | LINE_W | Line length in pixels |
| vtotal_i | input | LINE_W | Frame height in lines |
| vblank_start_i | input | LINE_W | First blanking line |
| ratio_i | input | RATIO_W | Pixels per timestamp tick |
| cur_ts_o | output | TS_W | Free-running timestamp |
| frame_ts_o | output | TS_W | Timestamp captured at last vblank |
| tear_o | output | 1 | Capture seen inside the read window |
| scanline_o | output | LINE_W | Derived current scanline |
| valid_o | output | 1 | New scanline result pulse |

## Verification
The capture logic and the read window guard can act in the same cycle. A vblank pulse that coincides with the rising edge of `rd_open_i` must still raise the tear flag and must also update the captured timestamp. The bench drives both inputs high on the same edge, then checks `tear_o` and `frame_ts_o` in the following cycle. A capture in the same cycle as a divider load is judged by requiring that the result two pulses after a vblank uses the new frame timestamp.

// File: rtl/fts_pkg.sv
package fts_pkg;
  function automatic logic [15:0] wrap_line(input logic [15:0] sum, input logic [15:0] vt);
    return (sum >= vt) ? sum - vt : sum;
  endfunction
endpackage

// File: rtl/fts_counter.sv
module fts_counter #(
  parameter int          TS_W     = 32,
  parameter int          TICK_DIV = 1,
  parameter logic [31:0] TS_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vblank_i,
  input  logic            rd_open_i,
  output logic [TS_W-1:0] cur_o,
  output logic [TS_W-1:0] frame_o,
  output logic            tear_o
);
  logic            tick;
  logic [TS_W-1:0] cur_q, frame_q;
  logic            tear_q;

  generate
    if (TICK_DIV <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV - 1))   pre_q <= '0;
        else                                   pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= TS_W'(TS_RESET);
      frame_q <= '0;
      tear_q  <= 1'b0;
    end else begin
      if (tick)     cur_q   <= cur_q + 1'b1;
      if (vblank_i) frame_q <= cur_q;
      tear_q <= rd_open_i & (tear_q | vblank_i);
    end
  end

  assign cur_o   = cur_q;
  assign frame_o = frame_q;
  assign tear_o  = tear_q;

  AST_CUR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cur_q == $past(cur_q) + 1'b1); // R2
  AST_FRAME_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> frame_q == $past(cur_q)); // R3
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(frame_q)); // R3
  AST_TEAR_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_open_i |=> !tear_q); // R8
endmodule

// File: rtl/fts_divider.sv
module fts_divider #(
  parameter int N_W = 48,
  parameter int D_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [N_W-1:0] quo_o,
  output logic           done_o
);
  localparam int CW = $clog2(N_W + 1);

  logic           busy_q, done_q;
  logic [CW-1:0]  cnt_q;
  logic [D_W:0]   rem_q;
  logic [D_W-1:0] den_q;
  logic [N_W-1:0] quo_q;
  logic [D_W:0]   r_sh, rem_nx;
  logic           ge;

  always_comb begin
    r_sh   = {rem_q[D_W-1:0], quo_q[N_W-1]};
    ge     = r_sh >= {1'b0, den_q};
    rem_nx = ge ? r_sh - {1'b0, den_q} : r_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(N_W);
        rem_q  <= '0;
        den_q  <= den_i;
        quo_q  <= num_i;
      end else begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[N_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R7
endmodule

// File: rtl/fts_scanline.sv
module fts_scanline #(
  parameter int N_W = 48,
  parameter int D_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] quo_i,
  input  logic           done_i,
  input  logic [D_W-1:0] vtotal_i,
  input  logic [D_W-1:0] vbs_i,
  output logic [D_W-1:0] line_o,
  output logic           valid_o
);
  import fts_pkg::*;

  logic [D_W-1:0] vt_m1, elapsed, line_d, line_q;
  logic [D_W:0]   sum;
  logic           have_q, valid_q;

  always_comb begin
    vt_m1   = vtotal_i - 1'b1;
    elapsed = (quo_i > N_W'(vt_m1)) ? vt_m1 : quo_i[D_W-1:0];
    sum     = {1'b0, elapsed} + {1'b0, vbs_i};
    line_d  = D_W'(wrap_line(16'(sum), 16'(vtotal_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done_i;
      if (done_i) begin
        line_q <= line_d;
        have_q <= 1'b1;
      end
    end
  end

  assign line_o  = have_q ? line_q : vbs_i;
  assign valid_o = valid_q;

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && vtotal_i != '0 && $stable(vtotal_i)) |-> line_q < vtotal_i); // R6
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !done_i) |=> $stable(line_q)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
endmodule

// File: rtl/frame_ts_unit.sv
module frame_ts_unit #(
  parameter int          TS_W     = 32,
  parameter int          LINE_W   = 13,
  parameter int          RATIO_W  = 16,
  parameter int          TICK_DIV = 1,
  parameter logic [31:0] TS_RESET = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vblank_i,
  input  logic               rd_open_i,
  input  logic [LINE_W-1:0]  htotal_i,
  input  logic [LINE_W-1:0]  vtotal_i,
  input  logic [LINE_W-1:0]  vblank_start_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [TS_W-1:0]    cur_ts_o,
  output logic [TS_W-1:0]    frame_ts_o,
  output logic               tear_o,
  output logic [LINE_W-1:0]  scanline_o,
  output logic               valid_o
);
  localparam int N_W = TS_W + RATIO_W;

  logic [TS_W-1:0] cur, frame, delta;
  logic [N_W-1:0]  num, quo;
  logic            done;

  fts_counter #(.TS_W(TS_W), .TICK_DIV(TICK_DIV), .TS_RESET(TS_RESET)) u_cnt (
    .clk_i, .rst_ni, .vblank_i, .rd_open_i,
    .cur_o(cur), .frame_o(frame), .tear_o
  );

  assign delta = cur - frame;
  assign num   = N_W'(delta) * N_W'(ratio_i);

  fts_divider #(.N_W(N_W), .D_W(LINE_W)) u_div (
    .clk_i, .rst_ni, .num_i(num), .den_i(htotal_i), .quo_o(quo), .done_o(done)
  );

  fts_scanline #(.N_W(N_W), .D_W(LINE_W)) u_line (
    .clk_i, .rst_ni, .quo_i(quo), .done_i(done),
    .vtotal_i, .vbs_i(vblank_start_i), .line_o(scanline_o), .valid_o
  );

  assign cur_ts_o   = cur;
  assign frame_ts_o = frame;

  AST_RESET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> scanline_o == vblank_start_i); // R9
endmodule

// File: tb/frame_ts_unit_test.sv
module frame_ts_unit_test;
  localparam int W   = 48;
  localparam int LAT = W + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vblank = 1'b0, rd_open = 1'b0;
  logic [12:0] htotal = 13'd100, vtotal = 13'd100, vbs = 13'd80;
  logic [15:0] ratio = 16'd20;
  logic [31:0] cur, frame, cur_w, frame_w;
  logic        tear, valid, tear_w, valid_w;
  logic [12:0] line, line_w;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  frame_ts_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .vblank_i(vblank), .rd_open_i(rd_open),
    .htotal_i(htotal), .vtotal_i(vtotal), .vblank_start_i(vbs), .ratio_i(ratio),
    .cur_ts_o(cur), .frame_ts_o(frame), .tear_o(tear), .scanline_o(line), .valid_o(valid)
  );

  frame_ts_unit #(.TS_RESET(32'hFFFF_FFC0)) uut_wrap (
    .clk_i(clk), .rst_ni(rst_n), .vblank_i(vblank), .rd_open_i(rd_open),
    .htotal_i(htotal), .vtotal_i(vtotal), .vblank_start_i(vbs), .ratio_i(ratio),
    .cur_ts_o(cur_w), .frame_ts_o(frame_w), .tear_o(tear_w), .scanline_o(line_w), .valid_o(valid_w)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_line(input longint unsigned d, input int r, input int ht,
                                      input int vt, input int vb);
    longint unsigned el, s;
    el = (ht == 0) ? longint'(vt - 1) : (d * r) / ht;
    if (el > vt - 1) el = vt - 1;
    s = el + vb;
    if (s >= vt) s = s - vt;
    return longint'(s);
  endfunction

  task automatic pulse_vblank();
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!valid) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cur == 0 && frame == 0, "R1 timestamps", longint'(cur) + frame, 0);
    chk(tear == 0 && valid == 0, "R1 flags", {tear, valid}, 0);
    chk(line == vbs, "R1 scanline", line, vbs);
    vbs = 13'd33;
    @(negedge clk);
    chk(line == 13'd33, "R9 follows vblank_start", line, 33);
    vbs = 13'd80;
  endtask

  task automatic t_count();
    logic [31:0] a;
    a = cur;
    repeat (5) @(negedge clk);
    chk(cur == a + 5, "R2 tick rate", cur, a + 5);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    pulse_vblank();
    wait_valid();
    @(negedge clk);
    while (!valid_w) @(negedge clk);
    d = cur_w - frame_w - LAT;
    chk(frame_w > cur_w, "R4 wrap happened", cur_w, frame_w);
    chk(line_w == exp_line(d, ratio, htotal, vtotal, vbs), "R4 wrapped delta",
        line_w, exp_line(d, ratio, htotal, vtotal, vbs));
  endtask

  task automatic t_capture();
    logic [31:0] c, f;
    vblank = 1'b1;
    c = cur;
    @(negedge clk);
    vblank = 1'b0;
    chk(frame == c, "R3 capture value", frame, c);
    f = frame;
    repeat (10) @(negedge clk);
    chk(frame == f, "R3 hold without pulse", frame, f);
  endtask

  task automatic t_scan(input int r, input int ht, input int vt, input int vb, input string req);
    logic [31:0] d;
    ratio = 16'(r); htotal = 13'(ht); vtotal = 13'(vt); vbs = 13'(vb);
    pulse_vblank();
    wait_valid();
    wait_valid();
    d = cur - frame - LAT;
    chk(line == exp_line(d, r, ht, vt, vb), req, line, exp_line(d, r, ht, vt, vb));
    chk(line < vtotal, "R6 range", line, vt);
  endtask

  task automatic t_period();
    int n;
    logic [12:0] l;
    wait_valid();
    l = line;
    n = 0;
    @(negedge clk);
    chk(!valid, "R7 one-cycle pulse", valid, 0);
    while (!valid) begin
      n++;
      if (n == 20) chk(line == l, "R7 hold between results", line, l);
      @(negedge clk);
    end
    chk(n + 1 == W + 1, "R7 result period", n + 1, W + 1);
  endtask

  task automatic t_tear();
    rd_open = 1'b1;
    repeat (5) @(negedge clk);
    chk(tear == 0, "R8 quiet window", tear, 0);
    pulse_vblank();
    chk(tear == 1, "R8 capture in window", tear, 1);
    repeat (3) @(negedge clk);
    chk(tear == 1, "R8 sticky while open", tear, 1);
    rd_open = 1'b0;
    @(negedge clk);
    chk(tear == 0, "R8 cleared when closed", tear, 0);
    pulse_vblank();
    chk(tear == 0, "R8 capture outside window", tear, 0);
    rd_open = 1'b1;
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
    chk(tear == 1, "R8 capture on window open", tear, 1);
    chk(frame == cur - 1, "R3 capture on window open", frame, cur - 1);
    rd_open = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_wrap();
    t_count();
    t_capture();
    t_scan(20, 100, 100, 80, "R6 modulo wrap");
    t_scan(3, 700, 525, 10, "R4 scaled elapsed");
    t_scan(100, 10, 50, 40, "R5 saturation");
    t_scan(7, 0, 90, 20, "R10 zero htotal");
    t_period();
    t_tear();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule